// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block keeps a negative flag and a zero flag for an 8-bit accumulator and uses them to decide conditional relative branches. When an accumulator operation of a flag-setting class (clear, test or increment) is presented, the flags are rewritten from that operation's 8-bit result on the next clock edge. Other cycles leave them as they are.

A branch instruction occupies two bytes: an opcode and a signed 8-bit displacement. The unit receives the displacement, a 2-bit condition selector and the address of the byte that follows the branch. On the next clock edge it registers the next program counter and a taken indication. If the condition holds, the next program counter is the following address plus the sign-extended displacement. If it does not, the next program counter is the following address itself. The unit sits between decode and fetch and returns the program counter that fetch should use next.

Top module: `cbu_branch_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any operation, `pc_next` is 0, `br_taken` is 0, and both `flag_n` and `flag_z` are 0.
- R2: An accepted operation with class code 2'b00 (clear) makes `flag_z` 1 and `flag_n` 0 one cycle later, whatever `acc_val` holds.
- R3: An accepted operation with class code 2'b01 (test) makes `flag_n` equal to bit 7 of `acc_val` and `flag_z` equal to 1 exactly when `acc_val` is zero, one cycle later.
- R4: An accepted operation with class code 2'b10 (increment) sets the flags from `acc_val` plus one, wrapped to 8 bits. So 8'hFF gives `flag_n`=0 and `flag_z`=1, and 8'h7F gives `flag_n`=1 and `flag_z`=0.
- R5: The flags keep their value in a cycle with `acc_op_vld` low, and also when the class code is 2'b11, even if `acc_val` changes.
- R6: For a taken branch, `pc_next` equals `br_pc_after` plus the 8-bit `br_disp` sign-extended to 16 bits, wrapped to 16 bits. For example, 0203 with 15 gives 0218, 2003 with F6 gives 1FF9, and 0050 with 80 gives FFD0.
- R7: For a branch that is not taken, `pc_next` equals `br_pc_after` and `br_taken` is 0.
- R8: Condition codes: 2'b00 always branches, 2'b01 branches when Z=1, 2'b10 branches when Z=0, and 2'b11 branches when N=1. `br_taken` shows the decision one cycle after `br_vld`.
- R9: A branch presented in the same cycle as a flag-setting operation is decided on the flags held before that operation.
- R10: `pc_next` and `br_taken` hold their last values in every cycle with `br_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_op_vld | input | 1 | An accumulator operation is presented this cycle |
| acc_op_cls | input | 2 | Operation class: 00 clear, 01 test, 10 increment, 11 no flag change |
| acc_val | input | 8 | Accumulator operand |
| br_vld | input | 1 | A branch is presented this cycle |
| br_cond | input | 2 | Condition: 00 always, 01 equal, 10 not equal, 11 minus |
| br_disp | input | 8 | Signed displacement byte |
| br_pc_after | input | 16 | Address of the byte after the branch |
| pc_next | output | 16 | Resolved next program counter |
| br_taken | output | 1 | Last resolved branch was taken |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The stimulus is a sequence of operations, each followed by a branch, so that every condition code is seen both taken and not taken. The increment of FF against the minus branch checks that wraparound clears N. Positive, negative and 16-bit-wrapping displacements check that the sign extension is right and that the wrap is not confused with a carry. One cycle presents a clear together with an equal branch, which shows whether the decision uses the old flags or the new ones. Idle and reserved-class cycles with a changing operand check that the state holds.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  typedef enum logic [1:0] {
    OPC_CLEAR = 2'b00,
    OPC_TEST  = 2'b01,
    OPC_INC   = 2'b10,
    OPC_NOP   = 2'b11
  } op_cls_e;

  typedef enum logic [1:0] {
    CND_ALWAYS = 2'b00,
    CND_EQ     = 2'b01,
    CND_NE     = 2'b10,
    CND_MI     = 2'b11
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
  } flags_t;

endpackage

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg
  import cbu_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic [1:0]       op_cls,
  input  logic [ACC_W-1:0] acc,
  output flags_t           flags_q
);

  localparam logic [ACC_W-1:0] ONE  = {{(ACC_W-1){1'b0}}, 1'b1};
  localparam logic [ACC_W-1:0] ONES = {ACC_W{1'b1}};

  logic [ACC_W-1:0] res;
  logic             upd;
  flags_t           flags_d;

  always_comb begin
    res = '0;
    upd = 1'b0;
    unique case (op_cls_e'(op_cls))
      OPC_CLEAR: begin res = '0;        upd = 1'b1; end
      OPC_TEST:  begin res = acc;       upd = 1'b1; end
      OPC_INC:   begin res = acc + ONE; upd = 1'b1; end
      default:   begin res = '0;        upd = 1'b0; end
    endcase
  end

  always_comb begin
    flags_d = flags_q;
    if (op_vld && upd) begin
      flags_d.n = res[ACC_W-1];
      flags_d.z = (res == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R2
  clear_sets_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_cls == OPC_CLEAR) |=> (flags_q.z && !flags_q.n));

  // R4
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_cls == OPC_INC && acc == ONES) |=> (flags_q.z && !flags_q.n));

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_vld || op_cls == OPC_NOP) |=> $stable(flags_q));

endmodule

// File: rtl/cbu_target_add.sv
module cbu_target_add #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  base,
  input  logic [OFF_W-1:0] disp,
  output logic [PC_W-1:0]  target
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
    end else begin : g_same
      assign disp_ext = disp[PC_W-1:0];
    end
  endgenerate

  assign target = base + disp_ext;

endmodule

// File: rtl/cbu_branch_sel.sv
module cbu_branch_sel
  import cbu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_vld,
  input  logic [1:0]       br_cond,
  input  logic [OFF_W-1:0] br_disp,
  input  logic [PC_W-1:0]  pc_after,
  input  flags_t           flags,
  output logic [PC_W-1:0]  pc_q,
  output logic             taken_q
);

  logic [PC_W-1:0] target;
  logic            cond_ok;
  logic [PC_W-1:0] pc_d;
  logic            taken_d;

  cbu_target_add #(.PC_W(PC_W), .OFF_W(OFF_W)) u_add (
    .base   (pc_after),
    .disp   (br_disp),
    .target (target)
  );

  always_comb begin
    unique case (cond_e'(br_cond))
      CND_ALWAYS: cond_ok = 1'b1;
      CND_EQ:     cond_ok = flags.z;
      CND_NE:     cond_ok = !flags.z;
      default:    cond_ok = flags.n;
    endcase
  end

  always_comb begin
    pc_d    = pc_q;
    taken_d = taken_q;
    if (br_vld) begin
      taken_d = cond_ok;
      pc_d    = cond_ok ? target : pc_after;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      taken_q <= taken_d;
    end
  end

  // R7
  fallthrough_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_vld && br_cond == CND_NE && flags.z) |=> (!taken_q && pc_q == $past(pc_after)));

  // R8
  minus_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_vld && br_cond == CND_MI && flags.n) |=> taken_q);

  // R10
  branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_vld |=> ($stable(pc_q) && $stable(taken_q)));

endmodule

// File: rtl/cbu_branch_unit.sv
module cbu_branch_unit
  import cbu_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8,
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_op_vld,
  input  logic [1:0]       acc_op_cls,
  input  logic [ACC_W-1:0] acc_val,
  input  logic             br_vld,
  input  logic [1:0]       br_cond,
  input  logic [OFF_W-1:0] br_disp,
  input  logic [PC_W-1:0]  br_pc_after,
  output logic [PC_W-1:0]  pc_next,
  output logic             br_taken,
  output logic             flag_n,
  output logic             flag_z
);

  flags_t flags;

  cbu_flag_reg #(.ACC_W(ACC_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_vld  (acc_op_vld),
    .op_cls  (acc_op_cls),
    .acc     (acc_val),
    .flags_q (flags)
  );

  cbu_branch_sel #(.PC_W(PC_W), .OFF_W(OFF_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .br_vld   (br_vld),
    .br_cond  (br_cond),
    .br_disp  (br_disp),
    .pc_after (br_pc_after),
    .flags    (flags),
    .pc_q     (pc_next),
    .taken_q  (br_taken)
  );

  assign flag_n = flags.n;
  assign flag_z = flags.z;

  // R9
  old_flags_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_vld && br_cond == CND_EQ && !flag_z && acc_op_vld && acc_op_cls == OPC_CLEAR)
      |=> (!br_taken && flag_z));

endmodule

// File: tb/tb_cbu_branch_unit.sv
`timescale 1ns/1ps
module tb_cbu_branch_unit;

  typedef struct packed {
    logic [15:0] pc;
    logic        tk;
    logic        n;
    logic        z;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        acc_op_vld;
  logic [1:0]  acc_op_cls;
  logic [7:0]  acc_val;
  logic        br_vld;
  logic [1:0]  br_cond;
  logic [7:0]  br_disp;
  logic [15:0] br_pc_after;
  logic [15:0] pc_next;
  logic        br_taken;
  logic        flag_n;
  logic        flag_z;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [15:0] m_pc;
  logic        m_tk, m_n, m_z;

  cbu_branch_unit dut (
    .clk(clk), .rst_n(rst_n),
    .acc_op_vld(acc_op_vld), .acc_op_cls(acc_op_cls), .acc_val(acc_val),
    .br_vld(br_vld), .br_cond(br_cond), .br_disp(br_disp), .br_pc_after(br_pc_after),
    .pc_next(pc_next), .br_taken(br_taken), .flag_n(flag_n), .flag_z(flag_z)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag, exp_t act, exp_t exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual pc=%h tk=%b n=%b z=%b expected pc=%h tk=%b n=%b z=%b",
               tag, act.pc, act.tk, act.n, act.z, exp.pc, exp.tk, exp.n, exp.z);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the model's outcome
  task automatic step(string tag, logic ov, logic [1:0] oc, logic [7:0] av,
                      logic bv, logic [1:0] bc, logic [7:0] bd, logic [15:0] bp);
    logic ok;
    logic [7:0] r;
    exp_t e;
    @(negedge clk);
    acc_op_vld = ov; acc_op_cls = oc; acc_val = av;
    br_vld = bv; br_cond = bc; br_disp = bd; br_pc_after = bp;
    if (bv) begin
      case (bc)
        2'b00: ok = 1'b1;
        2'b01: ok = m_z;
        2'b10: ok = !m_z;
        default: ok = m_n;
      endcase
      m_tk = ok;
      m_pc = ok ? bp + {{8{bd[7]}}, bd} : bp;
    end
    if (ov && oc != 2'b11) begin
      r = (oc == 2'b00) ? 8'h00 : (oc == 2'b01) ? av : av + 8'h01;
      m_n = r[7];
      m_z = (r == 8'h00);
    end
    e = '{pc: m_pc, tk: m_tk, n: m_n, z: m_z};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: samples one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, '{pc: pc_next, tk: br_taken, n: flag_n, z: flag_z}, e);
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    acc_op_vld = 0; acc_op_cls = 0; acc_val = 0;
    br_vld = 0; br_cond = 0; br_disp = 0; br_pc_after = 0;
    m_pc = 16'h0; m_tk = 0; m_n = 0; m_z = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", '{pc: pc_next, tk: br_taken, n: flag_n, z: flag_z}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '{pc: pc_next, tk: br_taken, n: flag_n, z: flag_z}, '0);

    step("R2 clear",                1, 2'b00, 8'h5A, 0, 2'b00, 8'h00, 16'h0000);
    step("R8 R6 equal taken",       0, 2'b00, 8'h00, 1, 2'b01, 8'h15, 16'h0203);
    step("R3 test FF",              1, 2'b01, 8'hFF, 0, 2'b00, 8'h00, 16'h0000);
    step("R6 minus negative disp",  0, 2'b00, 8'h00, 1, 2'b11, 8'hF6, 16'h2003);
    step("R4 increment FF",         1, 2'b10, 8'hFF, 0, 2'b00, 8'h00, 16'h0000);
    step("R7 minus falls through",  0, 2'b00, 8'h00, 1, 2'b11, 8'h11, 16'h2003);
    step("R8 not-equal with Z=1",   0, 2'b00, 8'h00, 1, 2'b10, 8'h10, 16'h1000);
    step("R3 test 05",              1, 2'b01, 8'h05, 0, 2'b00, 8'h00, 16'h0000);
    step("R8 not-equal with Z=0",   0, 2'b00, 8'h00, 1, 2'b10, 8'h10, 16'h1000);
    step("R5 R10 reserved class",   1, 2'b11, 8'h80, 0, 2'b11, 8'h7F, 16'hABCD);
    step("R6 always wraps",         0, 2'b00, 8'h00, 1, 2'b00, 8'h80, 16'h0050);
    step("R9 clear with equal",     1, 2'b00, 8'h33, 1, 2'b01, 8'h04, 16'h3000);
    step("R4 increment 7F",         1, 2'b10, 8'h7F, 0, 2'b00, 8'h00, 16'h0000);
    step("R5 R10 idle",             0, 2'b01, 8'h00, 0, 2'b00, 8'h01, 16'h4444);
    step("R8 minus with N=1",       0, 2'b00, 8'h00, 1, 2'b11, 8'h02, 16'h0100);

    @(negedge clk);
    acc_op_vld = 0; br_vld = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule